// File: doc/BRIEF.md
# Type 2 Tag Command Controller

This block is the protocol brain of an NFC-A Type 2 tag that carries a 7-byte UID and 64 bytes of static memory. A receive path outside the block demodulates the reader's frames, checks their CRC and strips it. That path hands the frame over one octet per cycle, followed by a frame-end strobe. The strobe carries the total payload bit count, a flag for 7-bit short frames and a CRC-good flag. The controller decides which state the tag moves to and what it answers. The answer is presented for one cycle as a block of up to 16 octets, together with an octet count, the number of leading bits of the first octet to suppress, a short-frame flag and a flag that asks the transmitter to append a CRC. Bit coding, response timing and CRC generation all live outside the block.

The tag walks through power-on idle, two cascade levels of anticollision and select, an active state for memory access, and a halted state. It accepts a read of block 0 as a shortcut straight into the active state. Anticollision frames may be cut by the reader at any bit, and the tag completes them from that bit. The 16 blocks of 4 octets are held in registers and initialised at reset from the UID and capability parameters.

Top module: `t2_tag_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `tag_state` is 0 (idle) and `resp_valid` is 0. State codes: 0 idle, 1 ready level 1, 2 ready level 2, 3 active, 4 halted.
- R2: In idle, a 7-bit short frame 0x26 or 0x52 is answered with the 2 octets 0x44, 0x00 (no CRC), and the state becomes 1. Any other frame gives no answer and leaves the state at 0.
- R3: In the halted state, only the 7-bit short frame 0x52 is acted on: it gives the same two-octet answer and moves to state 1. Everything else, 0x26 included, gives no answer and leaves the state at 4.
- R4: In state 1 or 2, a frame whose first octet is 0x93 (level 1) or 0x95 (level 2) and whose bit count B satisfies 16 <= B < 56 is an anticollision frame with P = B-16 known UID bits. The cascade octets are 0x88,U0,U1,U2,BCC0 at level 1 and U3,U4,U5,U6,BCC1 at level 2, where each BCC is the XOR of the four octets before it. If the P bits after the second octet (LSB first) equal the first P bits of the cascade octets, the answer is cascade octets P/8 to 4 in `resp_data` from octet 0, with `resp_nbytes` = 5-P/8, `resp_skip` = P mod 8 and no CRC. If they differ, there is no answer and the state is kept.
- R5: A select is a 56-bit frame in state 1 or 2 with the level's command octet, 0x70 as second octet, a good CRC and all 5 cascade octets matching. It is answered with one octet and a CRC: 0x04 with a move to state 2 at level 1, 0x00 with a move to state 3 at level 2.
- R6: In state 1 or 2, any frame that is not an anticollision frame, a valid select or a good-CRC read of block 0 gives no answer. It sends the tag to its home state: 4 if the tag has been halted since reset, otherwise 0.
- R7: In state 1 or 2, the 16-bit frame 0x30,0x00 with a good CRC moves the tag to state 3 and is answered with blocks 0..3 (16 octets, CRC appended).
- R8: In state 3, a 16-bit frame 0x30,A with a good CRC and A <= 0x0F is answered with the 16 octets of blocks A..A+3 with a CRC, wrapping from block 15 to block 0. Octet i of a block is `resp_data[8*(4*k+i)+:8]` for the k-th block sent. A > 0x0F or a bad CRC is answered with NAK, and the state is kept.
- R9: In state 3, a 48-bit frame 0xA2,A,D0..D3 with a good CRC and 2 <= A <= 15 stores D0..D3 as octets 0..3 of block A and is answered with ACK. Otherwise it is answered with NAK and memory is unchanged. ACK and NAK are 4-bit short frames with the values 0xA and 0x0, reported as `resp_short`=1, `resp_nbytes`=1.
- R10: In state 3, the 16-bit frame 0x50,0x00 with a good CRC moves the tag to state 4 with no answer. Any other unrecognised frame gives no answer and sends the tag to its home state (R6).
- R11: After reset, block 0 holds U0,U1,U2,BCC0, block 1 holds U3..U6, block 2 holds BCC1,0,0,0, block 3 holds the capability octets, and blocks 4..15 are zero.
- R12: An answer appears as a one-cycle `resp_valid` pulse in the cycle after the `rx_done` strobe. Octets are delivered in cycles before the strobe, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_valid | input | 1 | A received payload octet is present |
| rx_byte | input | 8 | Received payload octet, frame order |
| rx_done | input | 1 | Frame end strobe |
| rx_bits | input | 7 | Total payload bits of the frame, valid with rx_done |
| rx_short | input | 1 | Frame was a short frame, valid with rx_done |
| rx_crc_ok | input | 1 | Received CRC was good, valid with rx_done |
| resp_valid | output | 1 | One-cycle answer strobe |
| resp_short | output | 1 | Answer is a 4-bit short frame |
| resp_crc | output | 1 | Transmitter must append a CRC |
| resp_skip | output | 3 | Leading bits of octet 0 not to send |
| resp_nbytes | output | 5 | Number of answer octets |
| resp_data | output | 128 | Answer octets, octet 0 in the low bits |
| tag_state | output | 3 | Current protocol state code |

## Verification
Anticollision is exercised with a full-cascade request (no known bits), a breakpoint in the middle of an octet, and a prefix that differs in one bit. Together these separate the octet offset from the bit offset and show that a mismatch stays silent. Select and write frames are sent with good and bad CRC. Read and write addresses cover an in-range block, the wrap past block 15, a protected block and an address beyond the memory. Recovery paths run both from a tag that was halted and from one that never was, which tells the two home states apart.

// File: rtl/t2t_pkg.sv
package t2t_pkg;

    localparam int NUM_BLOCKS     = 16;
    localparam int BLK_BYTES      = 4;
    localparam int READ_BLOCKS    = 4;
    localparam int RESP_BYTES     = READ_BLOCKS * BLK_BYTES;
    localparam int CASC_BYTES     = 5;
    localparam int FIRST_WRITABLE = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY1 = 3'd1,
        ST_READY2 = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_HALT   = 3'd4
    } tag_state_e;

    localparam logic [7:0] OP_REQA   = 8'h26;
    localparam logic [7:0] OP_WUPA   = 8'h52;
    localparam logic [7:0] OP_SEL1   = 8'h93;
    localparam logic [7:0] OP_SEL2   = 8'h95;
    localparam logic [7:0] OP_READ   = 8'h30;
    localparam logic [7:0] OP_WRITE  = 8'hA2;
    localparam logic [7:0] OP_HALT   = 8'h50;
    localparam logic [7:0] NVB_ALL   = 8'h70;
    localparam logic [7:0] CASC_TAG  = 8'h88;
    localparam logic [7:0] SAK_NEXT  = 8'h04;
    localparam logic [7:0] SAK_LAST  = 8'h00;
    localparam logic [7:0] CODE_ACK  = 8'h0A;
    localparam logic [7:0] CODE_NAK  = 8'h00;
    localparam logic [15:0] ATQA_VAL = 16'h0044;

    typedef struct packed {
        logic                    valid;
        logic                    short_frame;
        logic                    with_crc;
        logic [2:0]              skip;
        logic [4:0]              nbytes;
        logic [8*RESP_BYTES-1:0] data;
    } resp_t;

    // Five cascade octets of one level, octet 0 in the low bits, BCC last.
    function automatic logic [39:0] cascade(logic [55:0] uid, logic level2);
        logic [31:0] body;
        logic [7:0]  bcc;
        body = level2 ? uid[55:24] : {uid[23:0], CASC_TAG};
        bcc  = body[7:0] ^ body[15:8] ^ body[23:16] ^ body[31:24];
        return {bcc, body};
    endfunction

    function automatic logic [31:0] init_block(logic [55:0] uid, logic [31:0] cc, int blk);
        logic [39:0] c1;
        logic [39:0] c2;
        c1 = cascade(uid, 1'b0);
        c2 = cascade(uid, 1'b1);
        case (blk)
            0:       return {c1[39:32], uid[23:0]};
            1:       return uid[55:24];
            2:       return {24'h0, c2[39:32]};
            3:       return cc;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/t2t_rx_frame.sv
module t2t_rx_frame #(
    parameter int FRAME_BYTES = 8,
    localparam int CW = $clog2(FRAME_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     octet_valid,
    input  logic [7:0]               octet,
    input  logic                     frame_end,
    output logic [8*FRAME_BYTES-1:0] frame
);
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            frame <= '0;
        end else if (frame_end) begin
            count <= '0;
            frame <= '0;
        end else if (octet_valid && count < CW'(FRAME_BYTES)) begin
            frame[8*count +: 8] <= octet;
            count               <= count + 1'b1;
        end
    end
endmodule

// File: rtl/t2t_store.sv
module t2t_store import t2t_pkg::*; #(
    parameter logic [55:0] UID = 56'h0,
    parameter logic [31:0] CC  = 32'h0,
    localparam int AW = $clog2(NUM_BLOCKS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [8*BLK_BYTES-1:0]          wr_data,
    input  logic [AW-1:0]                   rd_addr,
    output logic [8*RESP_BYTES-1:0]         rd_data
);
    logic [8*BLK_BYTES-1:0] blocks [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BLOCKS; b++)
                blocks[b] <= init_block(UID, CC, b);
        end else if (wr_en) begin
            blocks[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < READ_BLOCKS; g++) begin : g_rd
        assign rd_data[8*BLK_BYTES*g +: 8*BLK_BYTES] = blocks[AW'(rd_addr + AW'(g))];
    end

    // R9: the controller never asks to overwrite the identity blocks
    a_r9_protected_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr >= AW'(FIRST_WRITABLE));
endmodule

// File: rtl/t2t_casc.sv
module t2t_casc import t2t_pkg::*; #(
    parameter logic [55:0] UID = 56'h0
) (
    input  logic        level2,
    input  logic [39:0] rx_uid,
    input  logic [5:0]  nbits,
    output logic [39:0] casc,
    output logic        prefix_ok
);
    logic [39:0] mask;

    always_comb begin
        casc      = cascade(UID, level2);
        mask      = (nbits >= 6'd40) ? '1 : ((40'd1 << nbits) - 40'd1);
        prefix_ok = ((rx_uid ^ casc) & mask) == 40'd0;
    end
endmodule

// File: rtl/t2_tag_ctrl.sv
module t2_tag_ctrl import t2t_pkg::*; #(
    parameter logic [55:0] UID_VALUE   = 56'hF6E5D4C3B2A104,
    parameter logic [31:0] CC_VALUE    = 32'h000610E1,
    parameter int          FRAME_BYTES = 8,
    localparam int RESP_W = 8 * RESP_BYTES,
    localparam int AW     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_done,
    input  logic [6:0]        rx_bits,
    input  logic              rx_short,
    input  logic              rx_crc_ok,
    output logic              resp_valid,
    output logic              resp_short,
    output logic              resp_crc,
    output logic [2:0]        resp_skip,
    output logic [4:0]        resp_nbytes,
    output logic [RESP_W-1:0] resp_data,
    output logic [2:0]        tag_state
);
    logic [8*FRAME_BYTES-1:0] frame;
    logic [RESP_W-1:0]        rd_data;
    logic [39:0]              casc;
    logic                     prefix_ok;
    logic [5:0]               nbits;
    logic [6:0]               pbits;

    tag_state_e state_q, state_d;
    logic       halted_q, halted_d;
    resp_t      resp_q, resp_d;
    logic       wr_en;

    t2t_rx_frame #(.FRAME_BYTES(FRAME_BYTES)) i_frame (
        .clk(clk), .rst(rst), .octet_valid(rx_byte_valid), .octet(rx_byte),
        .frame_end(rx_done), .frame(frame));

    t2t_store #(.UID(UID_VALUE), .CC(CC_VALUE)) i_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(frame[8+:AW]),
        .wr_data(frame[47:16]), .rd_addr(frame[8+:AW]), .rd_data(rd_data));

    t2t_casc #(.UID(UID_VALUE)) i_casc (
        .level2(state_q == ST_READY2), .rx_uid(frame[55:16]), .nbits(nbits),
        .casc(casc), .prefix_ok(prefix_ok));

    logic [7:0] cmd, arg;
    logic       is_reqa, is_wupa, in_ready, is_acoll, is_select;
    logic       is_read, is_write, is_halt;
    tag_state_e home;

    always_comb begin
        cmd      = frame[7:0];
        arg      = frame[15:8];
        pbits    = rx_bits - 7'd16;
        if (rx_bits >= 7'd56)      nbits = 6'd40;
        else if (rx_bits >= 7'd16) nbits = pbits[5:0];
        else                       nbits = 6'd0;
        is_reqa  = rx_short && rx_bits == 7'd7 && cmd[6:0] == OP_REQA[6:0];
        is_wupa  = rx_short && rx_bits == 7'd7 && cmd[6:0] == OP_WUPA[6:0];
        in_ready = state_q == ST_READY1 || state_q == ST_READY2;
        is_acoll = in_ready && !rx_short && rx_bits >= 7'd16 && rx_bits < 7'd56 &&
                   cmd == ((state_q == ST_READY2) ? OP_SEL2 : OP_SEL1);
        is_select = in_ready && !rx_short && rx_bits == 7'd56 && arg == NVB_ALL &&
                    rx_crc_ok && prefix_ok &&
                    cmd == ((state_q == ST_READY2) ? OP_SEL2 : OP_SEL1);
        is_read  = !rx_short && rx_bits == 7'd16 && cmd == OP_READ;
        is_write = !rx_short && rx_bits == 7'd48 && cmd == OP_WRITE;
        is_halt  = !rx_short && rx_bits == 7'd16 && cmd == OP_HALT && arg == 8'h00;
        home     = halted_q ? ST_HALT : ST_IDLE;
    end

    always_comb begin
        state_d  = state_q;
        halted_d = halted_q;
        resp_d   = '0;
        wr_en    = 1'b0;
        if (rx_done) begin
            case (state_q)
                ST_IDLE, ST_HALT: begin
                    if (is_wupa || (is_reqa && state_q == ST_IDLE)) begin
                        resp_d.valid  = 1'b1;
                        resp_d.nbytes = 5'd2;
                        resp_d.data   = RESP_W'(ATQA_VAL);
                        state_d       = ST_READY1;
                    end
                end
                ST_READY1, ST_READY2: begin
                    if (is_acoll) begin
                        if (prefix_ok) begin
                            resp_d.valid  = 1'b1;
                            resp_d.skip   = pbits[2:0];
                            resp_d.nbytes = 5'(CASC_BYTES) - {2'b00, pbits[5:3]};
                            resp_d.data   = RESP_W'(casc >> {pbits[5:3], 3'b000});
                        end
                    end else if (is_select) begin
                        resp_d.valid    = 1'b1;
                        resp_d.with_crc = 1'b1;
                        resp_d.nbytes   = 5'd1;
                        resp_d.data     = RESP_W'((state_q == ST_READY2) ? SAK_LAST : SAK_NEXT);
                        state_d         = (state_q == ST_READY2) ? ST_ACTIVE : ST_READY2;
                    end else if (is_read && rx_crc_ok && arg == 8'h00) begin
                        resp_d.valid    = 1'b1;
                        resp_d.with_crc = 1'b1;
                        resp_d.nbytes   = 5'(RESP_BYTES);
                        resp_d.data     = rd_data;
                        state_d         = ST_ACTIVE;
                    end else begin
                        state_d = home;
                    end
                end
                ST_ACTIVE: begin
                    if (is_read || is_write) begin
                        resp_d.valid       = 1'b1;
                        resp_d.nbytes      = 5'd1;
                        resp_d.short_frame = 1'b1;
                        resp_d.data        = RESP_W'(CODE_NAK);
                        if (is_read && rx_crc_ok && arg < 8'(NUM_BLOCKS)) begin
                            resp_d.short_frame = 1'b0;
                            resp_d.with_crc    = 1'b1;
                            resp_d.nbytes      = 5'(RESP_BYTES);
                            resp_d.data        = rd_data;
                        end else if (is_write && rx_crc_ok && arg < 8'(NUM_BLOCKS) &&
                                     arg >= 8'(FIRST_WRITABLE)) begin
                            wr_en       = 1'b1;
                            resp_d.data = RESP_W'(CODE_ACK);
                        end
                    end else if (is_halt && rx_crc_ok) begin
                        state_d  = ST_HALT;
                        halted_d = 1'b1;
                    end else begin
                        state_d = home;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            halted_q <= 1'b0;
            resp_q   <= '0;
        end else begin
            state_q  <= state_d;
            halted_q <= halted_d;
            resp_q   <= resp_d;
        end
    end

    assign resp_valid  = resp_q.valid;
    assign resp_short  = resp_q.short_frame;
    assign resp_crc    = resp_q.with_crc;
    assign resp_skip   = resp_q.skip;
    assign resp_nbytes = resp_q.nbytes;
    assign resp_data   = resp_q.data;
    assign tag_state   = state_q;

    // R12: an answer only ever follows a frame end strobe
    a_r12_resp_after_done: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(rx_done));

    // R3: once halted, only a wake-up short frame releases the tag
    a_r3_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !(rx_done && is_wupa)) |=> state_q == ST_HALT);

    // R7: the active state is entered only from a ready state
    a_r7_active_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && $past(state_q) != ST_ACTIVE) |->
        ($past(state_q) == ST_READY1 || $past(state_q) == ST_READY2));

    // R9: ACK and NAK are single 4-bit frames without CRC
    a_r9_short_answer: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_short) |-> (resp_nbytes == 5'd1 && !resp_crc));

    // R4: a bit-split answer is an anticollision tail, never CRC-protected
    a_r4_split_tail: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_skip != 3'd0) |-> (!resp_crc && resp_nbytes <= 5'd5));
endmodule

// File: tb/test_t2_tag_ctrl.sv
module test_t2_tag_ctrl;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_byte_valid = 1'b0;
    logic [7:0]   rx_byte = 8'h00;
    logic         rx_done = 1'b0;
    logic [6:0]   rx_bits = 7'd0;
    logic         rx_short = 1'b0;
    logic         rx_crc_ok = 1'b0;
    logic         resp_valid, resp_short, resp_crc;
    logic [2:0]   resp_skip;
    logic [4:0]   resp_nbytes;
    logic [127:0] resp_data;
    logic [2:0]   tag_state;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    t2_tag_ctrl i_t2_tag_ctrl (
        .clk(clk), .rst(rst), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .rx_done(rx_done), .rx_bits(rx_bits), .rx_short(rx_short), .rx_crc_ok(rx_crc_ok),
        .resp_valid(resp_valid), .resp_short(resp_short), .resp_crc(resp_crc),
        .resp_skip(resp_skip), .resp_nbytes(resp_nbytes), .resp_data(resp_data),
        .tag_state(tag_state));

    typedef struct packed {
        logic [63:0] frm;
        logic [6:0]  bits;
        logic        shrt;
        logic        crc;
        logic [2:0]  st;
        logic        vld;
        logic        e_short;
        logic        e_crc;
        logic [2:0]  skip;
        logic [4:0]  nb;
        logic [39:0] dat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{64'h26,             7'd7,  1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 5'd2, 40'h0000000044},
        '{64'h2093,           7'd16, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 5'd5, 40'h9FB2A10488},
        '{64'h04883593,       7'd29, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd5, 5'd4, 40'h009FB2A104},
        '{64'h05882093,       7'd32, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0, 40'h0},
        '{64'h9FB2A104887093, 7'd56, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 3'd0, 5'd1, 40'h04},
        '{64'h2095,           7'd16, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 3'd0, 5'd5, 40'h04F6E5D4C3},
        '{64'h04F6E5D4C37095, 7'd56, 1'b0, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1, 3'd0, 5'd1, 40'h00},
        '{64'h4433221104A2,   7'd48, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 5'd1, 40'h0A},
        '{64'h4433221101A2,   7'd48, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 5'd1, 40'h00},
        '{64'h4433221105A2,   7'd48, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 5'd1, 40'h00},
        '{64'h4433221110A2,   7'd48, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 5'd1, 40'h00},
        '{64'h2030,           7'd16, 1'b0, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 5'd1, 40'h00},
        '{64'h0050,           7'd16, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0, 40'h0},
        '{64'h26,             7'd7,  1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0, 40'h0},
        '{64'h52,             7'd7,  1'b1, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 5'd2, 40'h0000000044},
        '{64'h0330,           7'd16, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0, 40'h0}
    };
    localparam string TAGS [NV] = '{"R2", "R4", "R4", "R4", "R5", "R4", "R5", "R9",
                                    "R9", "R9", "R9", "R8", "R10", "R3", "R3", "R6"};

    // Bench memory model built from the R11 layout
    logic [7:0] model [64];

    task automatic model_reset();
        logic [7:0] u [7];
        u = '{8'h04, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6};
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        model[0] = u[0]; model[1] = u[1]; model[2] = u[2];
        model[3] = 8'h88 ^ u[0] ^ u[1] ^ u[2];
        for (int i = 0; i < 4; i++) model[4 + i] = u[3 + i];
        model[8] = u[3] ^ u[4] ^ u[5] ^ u[6];
        model[12] = 8'hE1; model[13] = 8'h10; model[14] = 8'h06; model[15] = 8'h00;
    endtask

    function automatic logic [127:0] model_read(int a);
        logic [127:0] v;
        v = '0;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = model[(((a + i/4) % 16) * 4) + (i % 4)];
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] frm, input int bits, input logic s, input logic c);
        int n;
        n = (bits + 7) / 8;
        for (int i = 0; i < n; i++) begin
            rx_byte_valid = 1'b1;
            rx_byte       = frm[8*i +: 8];
            @(negedge clk);
        end
        rx_byte_valid = 1'b0;
        rx_done   = 1'b1;
        rx_bits   = 7'(bits);
        rx_short  = s;
        rx_crc_ok = c;
        @(negedge clk);
        rx_done   = 1'b0;
        rx_short  = 1'b0;
        rx_crc_ok = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check(tag_state == 3'd0 && !resp_valid, "R1", "reset state",
              {124'b0, resp_valid, tag_state}, 128'h0);

        // Scripted walk through the protocol
        for (int k = 0; k < NV; k++) begin
            send(TBL[k].frm, int'(TBL[k].bits), TBL[k].shrt, TBL[k].crc);
            check(tag_state == TBL[k].st, TAGS[k], $sformatf("vector %0d state", k),
                  128'(tag_state), 128'(TBL[k].st));
            if (TBL[k].vld)
                check(resp_valid && resp_short == TBL[k].e_short && resp_crc == TBL[k].e_crc &&
                      resp_skip == TBL[k].skip && resp_nbytes == TBL[k].nb &&
                      resp_data[39:0] == TBL[k].dat,
                      TAGS[k], $sformatf("vector %0d answer", k),
                      {resp_valid, resp_short, resp_crc, resp_skip, resp_nbytes, resp_data[39:0]},
                      {1'b1, TBL[k].e_short, TBL[k].e_crc, TBL[k].skip, TBL[k].nb, TBL[k].dat});
            else
                check(!resp_valid, TAGS[k], $sformatf("vector %0d silent", k),
                      128'(resp_valid), 128'h0);
        end

        // R1, R11: fresh tag, shortcut read of block 0
        do_reset();
        check(tag_state == 3'd0 && !resp_valid, "R1", "state after second reset",
              128'(tag_state), 128'h0);
        send(64'h26, 7, 1'b1, 1'b0);
        send(64'h0030, 16, 1'b0, 1'b1);
        check(tag_state == 3'd3, "R7", "read block 0 enters active", 128'(tag_state), 128'd3);
        check(resp_valid && resp_crc && resp_nbytes == 5'd16 && resp_data == model_read(0),
              "R11", "blocks 0..3 after reset", resp_data, model_read(0));
        // R12: pulse lasts exactly one cycle
        @(negedge clk);
        check(!resp_valid, "R12", "answer strobe is one cycle", 128'(resp_valid), 128'h0);

        // R9 and R8: write block 15 then read across the wrap
        send(64'hEFBEADDE0FA2, 48, 1'b0, 1'b1);
        check(resp_valid && resp_short && resp_data[7:0] == 8'h0A, "R9", "write block 15 ACK",
              128'(resp_data[7:0]), 128'h0A);
        model[60] = 8'hDE; model[61] = 8'hAD; model[62] = 8'hBE; model[63] = 8'hEF;
        send(64'h0E30, 16, 1'b0, 1'b1);
        check(resp_valid && resp_crc && resp_data == model_read(14), "R8", "read wraps past 15",
              resp_data, model_read(14));

        // R9: refused write to block 0 leaves memory unchanged
        send(64'h5566778800A2, 48, 1'b0, 1'b1);
        check(resp_valid && resp_short && resp_data[7:0] == 8'h00, "R9", "block 0 write NAK",
              128'(resp_data[7:0]), 128'h00);
        send(64'h0030, 16, 1'b0, 1'b1);
        check(resp_data == model_read(0), "R9", "block 0 unchanged", resp_data, model_read(0));

        // R8: bad CRC read gives NAK and keeps active
        send(64'h0430, 16, 1'b0, 1'b0);
        check(resp_valid && resp_short && tag_state == 3'd3, "R8", "bad CRC read NAK",
              {resp_valid, resp_short, tag_state}, {1'b1, 1'b1, 3'd3});

        // R10: unknown command in active returns to idle (never halted)
        send(64'h0060, 16, 1'b0, 1'b1);
        check(tag_state == 3'd0 && !resp_valid, "R10", "unknown command falls back to idle",
              128'(tag_state), 128'd0);

        // R2: idle ignores a read
        send(64'h0030, 16, 1'b0, 1'b1);
        check(tag_state == 3'd0 && !resp_valid, "R2", "idle ignores read",
              128'(tag_state), 128'd0);

        // R6: select with bad CRC sends the tag home to idle
        send(64'h26, 7, 1'b1, 1'b0);
        send(64'h9FB2A104887093, 56, 1'b0, 1'b0);
        check(tag_state == 3'd0 && !resp_valid, "R6", "bad select falls back to idle",
              128'(tag_state), 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule